// File: doc/BRIEF.md
# Forking Token Control Sequencer

This block is a synchronous control unit whose state register is a vector of one-hot bits, each bit acting as a token. Unlike an ordinary one-hot machine, several bits may be set together. A token leaves its state when that state's condition flag is high and otherwise waits. The controller built here follows a fixed flowchart with three parts. The first is a main thread. The second is a side branch that can be launched from either of two main states and that dies out by itself after its last state. The third is a join path, forked from a third main state, which meets the main thread again at a join state.

Every active state drives an action strobe in the same cycle that its condition flag is met, so the strobes mark the cycles in which each unit finishes its work and hands activation on. The surrounding logic starts a run with a one-cycle start pulse. It paces each state through its condition flag and watches the strobes, the state vector and the idle output. A fork into a branch that still holds a token is refused, and the refusal raises a sticky error flag.

Top module: `fork_seq`

## Requirements
With the default parameters, the state vector has the following layout. Bits 0 to 5 form the main thread M0..M5. Bits 6 to 8 form the side branch S0..S2. Bits 9 and 10 form the join path J0..J1. Bit 11 is the join state. Condition flag cond_i[k] and strobe act_o[k] belong to state bit k.

- R1: While rst_ni is low, and after it is released until the first start, state_o is 0, act_o is 0, idle_o is 1 and ovf_o is 0.
- R2: A start_i pulse sampled at a clock edge sets M0 (bit 0) from that edge on. Any tokens already present are kept.
- R3: A token in state k with cond_i[k] high moves to its successor at the next edge. With cond_i[k] low it stays in state k. The successors are M(i) to M(i+1), S(i) to S(i+1) and J0 to J1. act_o[k] equals state_o[k] AND cond_i[k], with no register in the path.
- R4: Several state bits set in the same cycle is normal operation and raises no error.
- R5: A token leaving M1 or M5 also launches a token into S0 at the same edge. A token leaving S2 disappears, and the main thread is not affected.
- R6: A token leaving M2 also launches a token into J0 at the same edge.
- R7: The join state (bit 11) is set at the edge after both of these events have happened: a token leaving M5 and a token leaving J1. They may happen in either order or in the same cycle, and each one is remembered until the join fires. Both remembered arrivals are cleared at the edge where the join is set. A token leaving the join state disappears.
- R8: A launch request into the side branch or into the join path while that branch already holds a token creates no second token. It sets ovf_o from the next edge on, and ovf_o stays set until reset.
- R9: idle_o is 1 exactly when no state bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sets the entry state M0 |
| cond_i | input | 12 | Per-state condition flags, bit k releases state k |
| state_o | output | 12 | Token vector, one bit per state |
| act_o | output | 12 | Per-state action strobes |
| idle_o | output | 1 | No token present |
| ovf_o | output | 1 | Sticky flag for a launch refused because the branch was busy |

## Verification
Two functions can fall in the same cycle: the two arrivals at the join, and a side-branch launch from M5 in the cycle the main thread arrives at the join. The bench holds the main thread at M5 while the join path steps on to J1. It then raises both condition flags together, and it expects the join state and a fresh S0 token in the very next state vector, with no overflow. A second run holds the side branch at S0. The later launch from M5 must then raise ovf_o without adding a token, while the join still waits for the late join path and fires once that path arrives.

// File: rtl/fork_seq_pkg.sv
package fork_seq_pkg;
  typedef struct packed {
    logic main_in;
    logic path_in;
  } join_flags_t;
endpackage

// File: rtl/token_chain.sv
module token_chain #(
  parameter int LEN = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           inject_i,
  input  logic [LEN-1:0] cond_i,
  output logic [LEN-1:0] bits_o,
  output logic           exit_o,
  output logic           busy_o
);
  logic [LEN-1:0] q, d, adv;

  assign adv = q & cond_i;

  for (genvar i = 0; i < LEN; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign d[i] = (q[i] & ~cond_i[i]) | inject_i;
    end else begin : g_body
      assign d[i] = (q[i] & ~cond_i[i]) | adv[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign bits_o = q;
  assign exit_o = adv[LEN-1];
  assign busy_o = |q;
endmodule

// File: rtl/fork_gate.sv
module fork_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic busy_i,
  output logic spawn_o,
  output logic ovf_o
);
  logic ovf_q;

  assign spawn_o = req_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ovf_q <= 1'b0;
    else if (req_i && busy_i) ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/join_cell.sv
module join_cell
  import fork_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        arr_main_i,
  input  logic        arr_path_i,
  input  logic        cond_i,
  output logic        bit_o,
  output join_flags_t flags_o
);
  join_flags_t flags_q, flags_d;
  logic        q, have_main, have_path, fire;

  assign have_main = flags_q.main_in | arr_main_i;
  assign have_path = flags_q.path_in | arr_path_i;
  assign fire      = have_main & have_path;

  always_comb begin
    if (fire) flags_d = '0;
    else      flags_d = '{main_in: have_main, path_in: have_path};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q       <= 1'b0;
      flags_q <= '0;
    end else begin
      q       <= (q & ~cond_i) | fire;
      flags_q <= flags_d;
    end
  end

  assign bit_o   = q;
  assign flags_o = flags_q;
endmodule

// File: rtl/fork_seq.sv
module fork_seq
  import fork_seq_pkg::*;
#(
  parameter  int MAIN_LEN  = 6,
  parameter  int SIDE_LEN  = 3,
  parameter  int PATH_LEN  = 2,
  parameter  int FORK_A    = 1,
  parameter  int FORK_B    = 5,
  parameter  int FORK_J    = 2,
  localparam int SIDE_LO   = MAIN_LEN,
  localparam int PATH_LO   = MAIN_LEN + SIDE_LEN,
  localparam int JOIN_BIT  = PATH_LO + PATH_LEN,
  localparam int NS        = JOIN_BIT + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NS-1:0] cond_i,
  output logic [NS-1:0] state_o,
  output logic [NS-1:0] act_o,
  output logic          idle_o,
  output logic          ovf_o
);
  logic [MAIN_LEN-1:0] main_bits;
  logic [SIDE_LEN-1:0] side_bits;
  logic [PATH_LEN-1:0] path_bits;
  logic                main_exit, side_exit, path_exit;
  logic                main_busy, side_busy, path_busy;
  logic                side_req, side_spawn, side_ovf;
  logic                path_req, path_spawn, path_ovf;
  logic                join_bit;
  join_flags_t         jflags;

  assign act_o = state_o & cond_i;

  token_chain #(.LEN(MAIN_LEN)) u_main (
    .clk_i, .rst_ni, .inject_i(start_i),
    .cond_i(cond_i[MAIN_LEN-1:0]),
    .bits_o(main_bits), .exit_o(main_exit), .busy_o(main_busy)
  );

  // side branch may be launched from two main states
  assign side_req = act_o[FORK_A] | act_o[FORK_B];
  assign path_req = act_o[FORK_J];

  fork_gate u_side_gate (
    .clk_i, .rst_ni, .req_i(side_req), .busy_i(side_busy),
    .spawn_o(side_spawn), .ovf_o(side_ovf)
  );

  fork_gate u_path_gate (
    .clk_i, .rst_ni, .req_i(path_req), .busy_i(path_busy),
    .spawn_o(path_spawn), .ovf_o(path_ovf)
  );

  token_chain #(.LEN(SIDE_LEN)) u_side (
    .clk_i, .rst_ni, .inject_i(side_spawn),
    .cond_i(cond_i[SIDE_LO +: SIDE_LEN]),
    .bits_o(side_bits), .exit_o(side_exit), .busy_o(side_busy)
  );

  token_chain #(.LEN(PATH_LEN)) u_path (
    .clk_i, .rst_ni, .inject_i(path_spawn),
    .cond_i(cond_i[PATH_LO +: PATH_LEN]),
    .bits_o(path_bits), .exit_o(path_exit), .busy_o(path_busy)
  );

  join_cell u_join (
    .clk_i, .rst_ni,
    .arr_main_i(main_exit), .arr_path_i(path_exit),
    .cond_i(cond_i[JOIN_BIT]),
    .bit_o(join_bit), .flags_o(jflags)
  );

  assign state_o = {join_bit, path_bits, side_bits, main_bits};
  assign idle_o  = ~(main_busy | side_busy | path_busy | join_bit);
  assign ovf_o   = side_ovf | path_ovf;

  // side_exit: token retires silently
  logic unused_side_exit;
  assign unused_side_exit = side_exit;
endmodule

// File: rtl/fork_seq_chk.sv
module fork_seq_chk
  import fork_seq_pkg::*;
#(
  parameter int MAIN_LEN = 6,
  parameter int SIDE_LEN = 3,
  parameter int PATH_LEN = 2,
  parameter int FORK_A   = 1,
  parameter int FORK_B   = 5,
  parameter int FORK_J   = 2,
  parameter int NS       = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NS-1:0] state_i,
  input logic [NS-1:0] act_i,
  input logic          idle_i,
  input logic          ovf_i,
  input join_flags_t   flags_i
);
  localparam int SIDE_LO  = MAIN_LEN;
  localparam int PATH_LO  = MAIN_LEN + SIDE_LEN;
  localparam int JOIN_BIT = PATH_LO + PATH_LEN;

  logic side_busy_req, path_busy_req;
  assign side_busy_req = (act_i[FORK_A] | act_i[FORK_B]) & (|state_i[SIDE_LO +: SIDE_LEN]);
  assign path_busy_req = act_i[FORK_J] & (|state_i[PATH_LO +: PATH_LEN]);

  assert_side_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(state_i[SIDE_LO +: SIDE_LEN]));

  assert_path_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(state_i[PATH_LO +: PATH_LEN]));

  assert_join_both_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_i[JOIN_BIT]) |->
      $past(flags_i.main_in | act_i[MAIN_LEN-1]) && $past(flags_i.path_in | act_i[JOIN_BIT-1]));

  assert_join_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_i[JOIN_BIT]) |-> (flags_i == '0));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (side_busy_req || path_busy_req) |=> ovf_i);

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_i);

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> (act_i == '0));
endmodule

bind fork_seq fork_seq_chk #(
  .MAIN_LEN(MAIN_LEN), .SIDE_LEN(SIDE_LEN), .PATH_LEN(PATH_LEN),
  .FORK_A(FORK_A), .FORK_B(FORK_B), .FORK_J(FORK_J), .NS(NS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_o), .act_i(act_o),
  .idle_i(idle_o), .ovf_i(ovf_o), .flags_i(jflags)
);

// File: tb/fork_seq_test.sv
`timescale 1ns/1ps
module fork_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] cond_i = '0;
  logic [11:0] state_o, act_o;
  logic        idle_o, ovf_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  fork_seq uut (
    .clk_i, .rst_ni, .start_i, .cond_i,
    .state_o, .act_o, .idle_o, .ovf_o
  );

  // {start, cond, expected act before edge, expected state after edge}
  localparam logic [36:0] TBL [13] = '{
    {1'b1, 12'hFFF, 12'h000, 12'h001},
    {1'b0, 12'hFFF, 12'h001, 12'h002},
    {1'b0, 12'hFFF, 12'h002, 12'h044},
    {1'b0, 12'hFFF, 12'h044, 12'h288},
    {1'b0, 12'hFFF, 12'h288, 12'h510},
    {1'b0, 12'hFFF, 12'h510, 12'h020},
    {1'b0, 12'hFFF, 12'h020, 12'h840},
    {1'b0, 12'hFFF, 12'h840, 12'h080},
    {1'b0, 12'hFFF, 12'h080, 12'h100},
    {1'b0, 12'hFFF, 12'h100, 12'h000},
    {1'b1, 12'h000, 12'h000, 12'h001},
    {1'b0, 12'h000, 12'h000, 12'h001},
    {1'b0, 12'h001, 12'h001, 12'h002}
  };

  task automatic check(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  task automatic apply(input logic st, input logic [11:0] c, input logic [11:0] ea,
                       input logic [11:0] en, input string tag);
    start_i = st;
    cond_i  = c;
    #1;
    check(act_o == ea, {tag, " act (R3)"}, act_o, ea);
    @(posedge clk_i);
    #1;
    start_i = 1'b0;
    check(state_o == en, {tag, " state"}, state_o, en);
  endtask

  task automatic do_reset();
    rst_ni  = 1'b0;
    start_i = 1'b0;
    cond_i  = '0;
    repeat (2) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1 reset state, with flags driven during reset
    cond_i = 12'hFFF;
    repeat (2) @(posedge clk_i);
    #1;
    check(state_o == 12'h000, "R1 state in reset", state_o, 12'h000);
    check(act_o == 12'h000, "R1 act in reset", act_o, 12'h000);
    check(idle_o == 1'b1, "R1 idle in reset", {11'b0, idle_o}, 12'h001);
    check(ovf_o == 1'b0, "R1 ovf in reset", {11'b0, ovf_o}, 12'h000);
    do_reset();
    check(state_o == 12'h000, "R1 state after release", state_o, 12'h000);

    // nominal run: R2 start, R5 forks from M1 and M5, R6 join path, R7 join, R4 overlap
    foreach (TBL[i]) begin
      apply(TBL[i][36], TBL[i][35:24], TBL[i][23:12], TBL[i][11:0],
            $sformatf("R4 R5 R6 R7 row %0d", i));
      if (i == 3) check(ovf_o == 1'b0, "R4 overlap no error", {11'b0, ovf_o}, 12'h000);
      if (i == 9) check(idle_o == 1'b1, "R9 idle after run", {11'b0, idle_o}, 12'h001);
    end
    check(ovf_o == 1'b0, "R4 nominal run ovf", {11'b0, ovf_o}, 12'h000);

    // side branch held busy: refused launch from M5, join waits for late path
    do_reset();
    apply(1'b1, 12'h03F, 12'h000, 12'h001, "R2 start");
    apply(1'b0, 12'h03F, 12'h001, 12'h002, "R3 step");
    apply(1'b0, 12'h03F, 12'h002, 12'h044, "R5 fork M1");
    apply(1'b0, 12'h03F, 12'h004, 12'h248, "R6 fork M2 side held");
    apply(1'b0, 12'h03F, 12'h008, 12'h250, "R3 hold");
    apply(1'b0, 12'h03F, 12'h010, 12'h260, "R3 hold2");
    check(ovf_o == 1'b0, "R8 no ovf yet", {11'b0, ovf_o}, 12'h000);
    apply(1'b0, 12'h03F, 12'h020, 12'h240, "R8 refused launch");
    check(ovf_o == 1'b1, "R8 ovf raised", {11'b0, ovf_o}, 12'h001);
    apply(1'b0, 12'h03F, 12'h000, 12'h240, "R7 join waits");
    apply(1'b0, 12'h03F, 12'h000, 12'h240, "R7 join waits2");
    apply(1'b0, 12'h600, 12'h200, 12'h440, "R3 path step");
    apply(1'b0, 12'h600, 12'h400, 12'h840, "R7 late path fires join");
    apply(1'b0, 12'h800, 12'h800, 12'h040, "R7 join exit");
    check(ovf_o == 1'b1, "R8 ovf sticky", {11'b0, ovf_o}, 12'h001);
    apply(1'b0, 12'h1C0, 12'h040, 12'h080, "R5 side S0");
    apply(1'b0, 12'h1C0, 12'h080, 12'h100, "R5 side S1");
    apply(1'b0, 12'h1C0, 12'h100, 12'h000, "R5 side dies");
    check(idle_o == 1'b1, "R9 idle", {11'b0, idle_o}, 12'h001);

    // both join arrivals in one cycle, with a side launch from M5 in that cycle
    do_reset();
    apply(1'b1, 12'h1FF, 12'h000, 12'h001, "R2 start");
    apply(1'b0, 12'h1FF, 12'h001, 12'h002, "R3 step");
    apply(1'b0, 12'h1FF, 12'h002, 12'h044, "R5 fork M1");
    apply(1'b0, 12'h1FF, 12'h044, 12'h288, "R6 fork M2");
    apply(1'b0, 12'h1FF, 12'h088, 12'h310, "R3 path held");
    apply(1'b0, 12'h1FF, 12'h110, 12'h220, "R5 side ends main at M5");
    check(idle_o == 1'b0, "R9 busy", {11'b0, idle_o}, 12'h000);
    apply(1'b0, 12'h200, 12'h200, 12'h420, "R3 path to J1");
    apply(1'b0, 12'h420, 12'h420, 12'h840, "R7 same-cycle arrivals");
    check(ovf_o == 1'b0, "R8 no false ovf", {11'b0, ovf_o}, 12'h000);
    apply(1'b0, 12'h000, 12'h000, 12'h840, "R7 no refire");
    apply(1'b0, 12'h840, 12'h840, 12'h080, "R7 join exit");

    finish_run();
  end
endmodule